// File: doc/BRIEF.md
# Controller Interrupt Status Aggregator

This block gathers the DMA-side and the SCSI-side event status of a bus host adapter into a single interrupt request level. It also decides, cycle by cycle, whether the script sequencer has to stop. Single-cycle event pulses set sticky status bits. Software programs per-bit enable masks through a byte-wide register port. Reading a status byte acknowledges it.

A software-interrupt request either raises a DMA status bit or sets a non-halting "interrupt on the fly" flag, depending on a qualifier input. SCSI events come in two kinds. Some are fatal and always stop the sequencer. Others stop it only when software has enabled them. A selection timeout never stops the sequencer at once. Instead it arms a deferred flag, and that flag stops the sequencer when it next issues an instruction that touches the bus.

Register map, by `regAddr`:

| Address | Register |
|---|---|
| 0 | interrupt status |
| 1 | DMA status |
| 2 | SCSI status A |
| 3 | SCSI status B |
| 4 | DMA enable |
| 5 | SCSI enable A |
| 6 | SCSI enable B |

An unmapped address reads as zero.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every status byte, every enable byte, the high nibble, the on-the-fly flag and the deferred flag are zero, so `intStatus`, `irq` and `haltReq` are all low.
- R2: `intStatus` bit 0 (DMA pending) is 1 exactly when DMA status AND DMA enable is nonzero.
- R3: `intStatus` bit 1 (SCSI pending) is 1 exactly when SCSI status A AND enable A, or SCSI status B AND enable B, is nonzero.
- R4: `irq` is high exactly when `intStatus` bit 0, bit 1 or bit 2 (on-the-fly) is set. It follows register changes in the cycle they become visible.
- R5: Status bits stay set until a read (`regRdEn`) of their own byte clears them at the clock edge. A bit that is set by an event in that same cycle survives the clear.
- R6: A read of the DMA status byte returns bit 7 as 1, whatever the stored value.
- R7: Any nonzero `dmaEvt` pulse gives a one-cycle `haltReq` in the following cycle.
- R8: SCSI status A bits 6, 5 and 4 request a halt only if their enable bit is set. The other bits of A always request a halt.
- R9: SCSI status B bits 1 and 0 request a halt only if enabled. Bit 2 (selection timeout) never requests an immediate halt. Bits 7 to 3 of B always request a halt.
- R10: A bit-2 event on `scsiEvt1` arms a deferred flag. The next `busInsn` strobe then gives a `haltReq` in the following cycle and disarms the flag.
- R11: A write to address 0 leaves `intStatus` bits 3..0 unchanged and stores data bits 7..4 as `intStatus` bits 7..4. Data bit 7 also sets DMA status bit 4 (abort), which halts like R7. Data bit 2 clears the on-the-fly flag.
- R12: `swIntReq` with `swIntFly`=1 sets the on-the-fly flag (`intStatus` bit 2) without a halt. With `swIntFly`=0 it sets DMA status bit 2 and halts like R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; acknowledges status bytes |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational, zero when not reading |
| dmaEvt | input | 8 | DMA event pulses, one per status bit |
| scsiEvt0 | input | 8 | SCSI status A event pulses |
| scsiEvt1 | input | 8 | SCSI status B event pulses |
| swIntReq | input | 1 | Software interrupt request pulse |
| swIntFly | input | 1 | Selects the non-halting on-the-fly form |
| busInsn | input | 1 | Sequencer starts a bus-touching instruction |
| intStatus | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request level |
| haltReq | output | 1 | One-cycle halt request to the sequencer |

## Verification
The properties assume that event inputs, `busInsn` and the register strobes are known values after reset. They also assume that each read strobe is meant as one acknowledgement, because every cycle with `regRdEn` high on a status address clears that byte. The stimulus changes every input on the falling clock edge and holds each access or pulse for exactly one cycle. It keeps timeout events out of the vector table so that no deferred flag leaks from one vector into the next. The collision case (read-clear and a new event in the same cycle) is driven on purpose as one combined cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NUM_SRC = 3;            // 0: DMA, 1: SCSI A, 2: SCSI B

  localparam int ADDR_INTSTAT   = 0;
  localparam int ADDR_STAT_BASE = 1;
  localparam int ADDR_EN_BASE   = 4;

  // Conditional SCSI events halt only when enabled.
  localparam logic [DW-1:0] A_COND_MASK  = 8'h70;
  localparam logic [DW-1:0] B_COND_MASK  = 8'h03;
  localparam logic [DW-1:0] B_DEFER_MASK = 8'h04;
  localparam logic [DW-1:0] DMA_RD_FORCE = 8'h80;

  localparam int ABORT_BIT = 4;          // DMA status bit set by the abort write
  localparam int SWINT_BIT = 2;          // DMA status bit set by a halting software interrupt
  localparam int WR_ABORT  = 7;          // interrupt status data bit requesting abort
  localparam int WR_FLYCLR = 2;          // interrupt status data bit clearing the fly flag

  typedef struct packed {
    logic [NUM_SRC-1:0] wrEn;            // write enable byte i
    logic [NUM_SRC-1:0] clrStat;         // read-clear status byte i
    logic               wrIntHi;
    logic               abortSet;
    logic               swDmaSet;
    logic               flySet;
    logic               flyClr;
  } strobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic          wrAbortBit,
  input  logic          wrFlyClrBit,
  input  logic          swIntReq,
  input  logic          swIntFly,
  input  logic          busInsn,
  input  logic [DW-1:0] dmaEvt,
  input  logic [DW-1:0] scsiEvt0,
  input  logic [DW-1:0] scsiEvt1,
  input  logic [DW-1:0] scsiEn0,
  input  logic [DW-1:0] scsiEn1,
  output strobe_t       strobe,
  output logic          haltReq
);
  logic deferFlag;
  logic fatalA, fatalB, deferHit, stoEvt, haltNext;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      strobe.wrEn[i]    = regWrEn && (regAddr == AW'(ADDR_EN_BASE + i));
      strobe.clrStat[i] = regRdEn && (regAddr == AW'(ADDR_STAT_BASE + i));
    end
    strobe.wrIntHi  = regWrEn && (regAddr == AW'(ADDR_INTSTAT));
    strobe.abortSet = strobe.wrIntHi && wrAbortBit;
    strobe.flyClr   = strobe.wrIntHi && wrFlyClrBit;
    strobe.swDmaSet = swIntReq && !swIntFly;
    strobe.flySet   = swIntReq && swIntFly;
  end

  always_comb begin
    fatalA   = |(scsiEvt0 & (scsiEn0 | ~A_COND_MASK));
    fatalB   = |(scsiEvt1 & (scsiEn1 | ~B_COND_MASK) & ~B_DEFER_MASK);
    stoEvt   = |(scsiEvt1 & B_DEFER_MASK);
    deferHit = busInsn && deferFlag;
    haltNext = (|dmaEvt) || strobe.abortSet || strobe.swDmaSet ||
               fatalA || fatalB || deferHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReq   <= 1'b0;
      deferFlag <= 1'b0;
    end else begin
      haltReq   <= haltNext;
      deferFlag <= stoEvt || (deferFlag && !busInsn);
    end
  end

  AST_DMA_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaEvt) |=> haltReq); // R7

  AST_DEFER_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (busInsn && deferFlag) |=> haltReq); // R10

  AST_DEFER_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (busInsn && !stoEvt) |=> !deferFlag); // R10

  AST_STO_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (scsiEvt1 == B_DEFER_MASK && dmaEvt == '0 && scsiEvt0 == '0 &&
     !swIntReq && !regWrEn && !busInsn) |=> !haltReq); // R9

  AST_FLY_NO_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flySet && dmaEvt == '0 && scsiEvt0 == '0 && scsiEvt1 == '0 &&
     !regWrEn && !busInsn) |=> !haltReq); // R12
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic [DW-1:0] dmaEvt,
  input  logic [DW-1:0] scsiEvt0,
  input  logic [DW-1:0] scsiEvt1,
  output logic [DW-1:0] scsiEn0,
  output logic [DW-1:0] scsiEn1,
  output logic [DW-1:0] regRdData,
  output logic [DW-1:0] intStatus,
  output logic          irq
);
  localparam int HW = DW / 2;

  logic [NUM_SRC-1:0][DW-1:0] statQ;
  logic [NUM_SRC-1:0][DW-1:0] enQ;
  logic [NUM_SRC-1:0][DW-1:0] setVec;
  logic [HW-1:0]              hiNib;
  logic                       flyQ;
  logic                       dmaPend, scsiPend;

  always_comb begin
    setVec[0] = dmaEvt;
    setVec[0][ABORT_BIT] = dmaEvt[ABORT_BIT] | strobe.abortSet;
    setVec[0][SWINT_BIT] = dmaEvt[SWINT_BIT] | strobe.swDmaSet;
    setVec[1] = scsiEvt0;
    setVec[2] = scsiEvt1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enQ   <= '0;
      hiNib <= '0;
      flyQ  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        statQ[i] <= (strobe.clrStat[i] ? '0 : statQ[i]) | setVec[i];
        if (strobe.wrEn[i]) enQ[i] <= regWrData;
      end
      if (strobe.wrIntHi) hiNib <= regWrData[DW-1:HW];
      flyQ <= strobe.flySet || (flyQ && !strobe.flyClr);
    end
  end

  always_comb begin
    dmaPend   = |(statQ[0] & enQ[0]);
    scsiPend  = |(statQ[1] & enQ[1]) || |(statQ[2] & enQ[2]);
    intStatus = {hiNib, 1'b0, flyQ, scsiPend, dmaPend};
    irq       = dmaPend || scsiPend || flyQ;
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      if (regAddr == AW'(ADDR_INTSTAT)) regRdData = intStatus;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (regAddr == AW'(ADDR_STAT_BASE + i))
          regRdData = statQ[i] | ((i == 0) ? DMA_RD_FORCE : '0);
        if (regAddr == AW'(ADDR_EN_BASE + i))
          regRdData = enQ[i];
      end
    end
  end

  assign scsiEn0 = enQ[1];
  assign scsiEn1 = enQ[2];

  AST_STICKY_DMA: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrStat[0] |=> ((statQ[0] & $past(statQ[0])) == $past(statQ[0]))); // R5

  AST_STICKY_SCSI: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrStat[1] |=> ((statQ[1] & $past(statQ[1])) == $past(statQ[1]))); // R5

  AST_DMA_RD_B7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == AW'(ADDR_STAT_BASE)) |-> regRdData[DW-1]); // R6

  AST_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrIntHi |=> (intStatus[DW-1:HW] == $past(regWrData[DW-1:HW]))); // R11

  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (statQ == '0 && !flyQ) |-> !irq); // R4
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic [DW-1:0] dmaEvt,
  input  logic [DW-1:0] scsiEvt0,
  input  logic [DW-1:0] scsiEvt1,
  input  logic          swIntReq,
  input  logic          swIntFly,
  input  logic          busInsn,
  output logic [DW-1:0] intStatus,
  output logic          irq,
  output logic          haltReq
);
  strobe_t       strobe;
  logic [DW-1:0] scsiEn0, scsiEn1;

  irq_agg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .wrAbortBit(regWrData[WR_ABORT]),
    .wrFlyClrBit(regWrData[WR_FLYCLR]), .swIntReq(swIntReq),
    .swIntFly(swIntFly), .busInsn(busInsn), .dmaEvt(dmaEvt),
    .scsiEvt0(scsiEvt0), .scsiEvt1(scsiEvt1), .scsiEn0(scsiEn0),
    .scsiEn1(scsiEn1), .strobe(strobe), .haltReq(haltReq)
  );

  irq_agg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .dmaEvt(dmaEvt),
    .scsiEvt0(scsiEvt0), .scsiEvt1(scsiEvt1), .scsiEn0(scsiEn0),
    .scsiEn1(scsiEn1), .regRdData(regRdData), .intStatus(intStatus),
    .irq(irq)
  );
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] dmaEvt = '0, scsiEvt0 = '0, scsiEvt1 = '0;
  logic       swIntReq = 1'b0, swIntFly = 1'b0, busInsn = 1'b0;
  logic [7:0] intStatus;
  logic       irq, haltReq;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  irq_status_agg dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dmaEvt(dmaEvt), .scsiEvt0(scsiEvt0), .scsiEvt1(scsiEvt1),
    .swIntReq(swIntReq), .swIntFly(swIntFly), .busInsn(busInsn),
    .intStatus(intStatus), .irq(irq), .haltReq(haltReq)
  );

  typedef struct packed {
    logic [7:0] dEn, aEn, bEn, dEv, aEv, bEv;
    logic       expIrq, expHalt;
    logic [1:0] expPend;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 2'b00},
    '{8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1, 1'b1, 2'b01},
    '{8'h02, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 2'b00},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 1'b0, 1'b0, 2'b00},
    '{8'h00, 8'h40, 8'h00, 8'h00, 8'h40, 8'h00, 1'b1, 1'b1, 2'b10},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, 2'b00},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 1'b0, 2'b00},
    '{8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1, 1'b1, 2'b10},
    '{8'h00, 8'h20, 8'h00, 8'h00, 8'h10, 8'h00, 1'b0, 1'b0, 2'b00},
    '{8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1, 2'b10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] d, input logic [7:0] a, input logic [7:0] b);
    dmaEvt = d; scsiEvt0 = a; scsiEvt1 = b;
    @(negedge clk);
    dmaEvt = '0; scsiEvt0 = '0; scsiEvt1 = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    string tHalt, tPend;
    idle(2);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 intStatus", intStatus, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 haltReq", {7'b0, haltReq}, 8'h00);
    rdReg(3'd5, rd); chk("R1 enable A", rd, 8'h00);
    rdReg(3'd1, rd); chk("R6 empty DMA status read", rd, 8'h80);

    // Table: enables, one event pulse, then acknowledge everything.
    for (int v = 0; v < NV; v++) begin
      wrReg(3'd4, VECS[v].dEn);
      wrReg(3'd5, VECS[v].aEn);
      wrReg(3'd6, VECS[v].bEn);
      pulseEvt(VECS[v].dEv, VECS[v].aEv, VECS[v].bEv);
      tHalt = (VECS[v].dEv != 0) ? "R7" : (VECS[v].aEv != 0) ? "R8" : "R9";
      tPend = (VECS[v].dEv != 0) ? "R2" : "R3";
      chk($sformatf("%s halt vec%0d", tHalt, v), {7'b0, haltReq}, {7'b0, VECS[v].expHalt});
      chk($sformatf("R4 irq vec%0d", v), {7'b0, irq}, {7'b0, VECS[v].expIrq});
      chk($sformatf("%s pending vec%0d", tPend, v), {6'b0, intStatus[1:0]}, {6'b0, VECS[v].expPend});
      rdReg(3'd1, rd); rdReg(3'd2, rd); rdReg(3'd3, rd);
    end
    chk("R5 irq after acknowledge", {7'b0, irq}, 8'h00);

    // R5: sticky until read, irq drops with the clear
    wrReg(3'd4, 8'h08);
    wrReg(3'd6, 8'h00);
    pulseEvt(8'h08, 8'h00, 8'h00);
    idle(3);
    chk("R5 sticky irq", {7'b0, irq}, 8'h01);
    rdReg(3'd1, rd);
    chk("R5 R6 read value", rd, 8'h88);
    chk("R5 irq after read", {7'b0, irq}, 8'h00);
    rdReg(3'd1, rd);
    chk("R5 cleared value", rd, 8'h80);

    // R5: event in the same cycle as the clearing read survives
    regRdEn = 1'b1; regAddr = 3'd2; scsiEvt0 = 8'h02;
    @(negedge clk);
    regRdEn = 1'b0; scsiEvt0 = '0;
    rdReg(3'd2, rd);
    chk("R5 set wins over clear", rd, 8'h02);

    // R11: write keeps low nibble, abort bit raises DMA bit 4
    wrReg(3'd4, 8'h10);
    wrReg(3'd0, 8'hA3);
    chk("R11 abort halts", {7'b0, haltReq}, 8'h01);
    chk("R11 status byte", intStatus, 8'hA1);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    rdReg(3'd1, rd);
    chk("R11 abort bit", rd, 8'h90);
    wrReg(3'd0, 8'h00);
    chk("R11 high nibble cleared", intStatus, 8'h00);

    // R12: on-the-fly interrupt, then its clear by write
    swIntReq = 1'b1; swIntFly = 1'b1;
    @(negedge clk);
    swIntReq = 1'b0; swIntFly = 1'b0;
    chk("R12 fly no halt", {7'b0, haltReq}, 8'h00);
    chk("R12 fly status", intStatus, 8'h04);
    chk("R4 fly irq", {7'b0, irq}, 8'h01);
    wrReg(3'd0, 8'h04);
    chk("R11 fly cleared", intStatus, 8'h00);
    chk("R11 irq after fly clear", {7'b0, irq}, 8'h00);

    // R12: halting software interrupt
    wrReg(3'd4, 8'h04);
    swIntReq = 1'b1;
    @(negedge clk);
    swIntReq = 1'b0;
    chk("R12 sw halt", {7'b0, haltReq}, 8'h01);
    chk("R12 sw pending", {7'b0, intStatus[0]}, 8'h01);
    rdReg(3'd1, rd);
    chk("R12 sw bit", rd, 8'h84);

    // R9 / R10: deferred timeout
    wrReg(3'd6, 8'h04);
    pulseEvt(8'h00, 8'h00, 8'h04);
    chk("R9 timeout no halt", {7'b0, haltReq}, 8'h00);
    chk("R3 timeout pending", intStatus, 8'h02);
    idle(1);
    chk("R10 still no halt", {7'b0, haltReq}, 8'h00);
    busInsn = 1'b1;
    @(negedge clk);
    busInsn = 1'b0;
    chk("R10 deferred halt", {7'b0, haltReq}, 8'h01);
    busInsn = 1'b1;
    @(negedge clk);
    busInsn = 1'b0;
    chk("R10 flag disarmed", {7'b0, haltReq}, 8'h00);
    rdReg(3'd3, rd);
    chk("R10 timeout bit", rd, 8'h04);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule